// File: doc/BRIEF.md
# ATAPI Command and Packet Intake Controller

This block is the device-side task-file front end of a packet-command storage device. The host writes the command, feature and count registers. After a PACKET command it sends a twelve-byte command block as six 16-bit PIO data writes. The block gathers those words into one wide packet and offers it to a downstream packet executor through a valid/ready pair. It then waits for the executor's 16-bit completion code.

The completion code is folded into the status, error and sense registers. A NOP command aborts whatever is in progress, and a device-reset command restores the power-on register image. Interrupt requests reach the interrupt controller as single-cycle raise and clear pulses. The block tracks one pending flag, so it emits a clear only when a request is outstanding.

Top module: `atapi_cmd_intake`

## Requirements
- R1: After reset, and after a device-reset command (0x08), status=0x50, error=0x01, count=0x01, byte-count low=0x81, byte-count high=0xEB, sector=0x14, and all ten sense bytes are 0x00.
- R2: A PACKET command (0xA0) sets status to 0x58 (DRDY 0x40, DRQ 0x08, SERV 0x10), sets count to 0x01 (command/data indication) and sets error to {6'b0, feature[1:0]}.
- R3: In the command-write phase each PIO write stores one word, with byte 2k = word k bits 7:0 and byte 2k+1 = word k bits 15:8. Packet byte i occupies pkt_data[8i+7:8i]. On the sixth word, status drops DRQ and gains BSY (0x80), so 0x58 becomes 0xD0, and pkt_valid rises.
- R4: PIO data writes made outside the command-write phase change neither the packet contents nor the status.
- R5: While pkt_valid is high and pkt_ready is low, pkt_valid and pkt_data hold. pkt_valid falls in the cycle after a cycle with pkt_ready high.
- R6: An accepted completion code C sets sense byte 0 to 0xF0, sense byte 2 to C[7:0], sense byte 8 to C[15:8], and error to {C[3:0], 4'h0}.
- R7: A nonzero code sets status to 0x51 and produces an irq_raise pulse. A zero code clears only BSY and CHK (bit 0), so 0xD0 becomes 0x50, and produces no interrupt.
- R8: A completion code is taken only while busy and after the packet has been accepted. Codes offered in any other cycle are ignored.
- R9: A NOP command (0x00) returns to idle, sets status 0x51 and error 0x04, and pulses irq_raise.
- R10: A set-feature command (0xEF) pulses irq_raise. When the feature register holds 0x03, xfer_class takes count[7:3]; with any other feature value, xfer_class is unchanged.
- R11: After every command except NOP, status bits DRDY and SERV are set and CHK is cleared. An unknown opcode therefore turns status 0x51 into 0x50.
- R12: A command write while an interrupt is pending emits an irq_clear pulse unless that same command raises again. irq_raise and irq_clear never pulse together.
- R13: When a command write and an acceptable completion code arrive in the same cycle, the command takes effect and the code is discarded; the sense bytes are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command opcode |
| feat_we | input | 1 | Feature register write strobe |
| feat_data | input | 8 | Feature value |
| cnt_we | input | 1 | Count register write strobe |
| cnt_data | input | 8 | Count value |
| pio_we | input | 1 | PIO data write strobe |
| pio_data | input | 16 | PIO data word |
| pkt_valid | output | 1 | Complete packet offered to executor |
| pkt_ready | input | 1 | Executor accepts the packet |
| pkt_data | output | 96 | Packet bytes, byte i at bits 8i+7:8i |
| res_valid | input | 1 | Completion code strobe |
| res_code | input | 16 | Completion code |
| status | output | 8 | Status register |
| error | output | 8 | Error register |
| count | output | 8 | Count / interrupt-reason register |
| bcnt_lo | output | 8 | Byte-count low register |
| bcnt_hi | output | 8 | Byte-count high register |
| sector | output | 8 | Sector register |
| sense | output | 80 | Sense bytes, byte i at bits 8i+7:8i |
| xfer_class | output | 5 | Recorded transfer-mode class |
| irq_raise | output | 1 | Interrupt raise pulse |
| irq_clear | output | 1 | Interrupt clear pulse |

## Verification
A command write and the executor's completion code can land in the same clock cycle. Both update status and error, and both can drive the interrupt pulses. The bench provokes this by holding a packet in the busy state until the executor has accepted it. It then drives a NOP and a nonzero completion code on the same edge. The outcome is judged correct when the registers show the NOP's abort values, the sense bytes keep the previous code's values, and exactly one raise pulse appears.

// File: rtl/atapi_pkg.sv
// Package: shared constants and types for the ATAPI command intake block.
// Assumes 8-bit task-file registers and one-hot status bit positions.
package atapi_pkg;

    typedef enum logic [1:0] {
        TF_IDLE  = 2'd0,
        TF_CMDWR = 2'd1,
        TF_BUSY  = 2'd2
    } tf_state_t;

    localparam logic [7:0] OP_NOP     = 8'h00;
    localparam logic [7:0] OP_DEVRST  = 8'h08;
    localparam logic [7:0] OP_PACKET  = 8'hA0;
    localparam logic [7:0] OP_SETFEAT = 8'hEF;
    localparam logic [7:0] FEAT_XMODE = 8'h03;

    localparam logic [7:0] SB_BSY  = 8'h80;
    localparam logic [7:0] SB_DRDY = 8'h40;
    localparam logic [7:0] SB_SERV = 8'h10;
    localparam logic [7:0] SB_DRQ  = 8'h08;
    localparam logic [7:0] SB_CHK  = 8'h01;

    localparam logic [7:0] RST_STATUS = 8'h50;
    localparam logic [7:0] RST_ERROR  = 8'h01;
    localparam logic [7:0] RST_COUNT  = 8'h01;
    localparam logic [7:0] RST_BCLO   = 8'h81;
    localparam logic [7:0] RST_BCHI   = 8'hEB;
    localparam logic [7:0] RST_SECTOR = 8'h14;

    localparam logic [7:0] IRSN_CMD    = 8'h01;
    localparam logic [7:0] STAT_FAIL   = 8'h51;
    localparam logic [7:0] ERR_ABORTED = 8'h04;
    localparam logic [7:0] SENSE_TAG   = 8'hF0;

endpackage

// File: rtl/atapi_pkt_collect.sv
// Module: gathers PIO words into one packet and holds it for the executor.
// Assumes wr_en is asserted only in the command-write phase; flush is
// asserted on every command write and drops any partial or offered packet.
module atapi_pkt_collect #(
    parameter int PKT_BYTES = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   wr_en,
    input  logic [15:0]            wr_word,
    input  logic                   ready,
    output logic                   pkt_valid,
    output logic [PKT_BYTES*8-1:0] pkt_data,
    output logic                   done
);
    localparam int NWORDS = PKT_BYTES / 2;
    localparam int IDX_W  = $clog2(NWORDS + 1);

    logic [IDX_W-1:0] widx;

    assign done = wr_en && (widx == IDX_W'(NWORDS - 1));

    // Word index: restarts on flush and after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n)      widx <= '0;
        else if (flush)  widx <= '0;
        else if (wr_en)  widx <= done ? '0 : widx + 1'b1;
    end

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic [15:0] word_q;
        // Word storage: captures the data word addressed by the index.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  word_q <= '0;
            else if (wr_en && widx == IDX_W'(k))         word_q <= wr_word;
        end
        assign pkt_data[16*k +: 16] = word_q;
    end

    // Offer flag: set on the last word, cleared by acceptance or flush.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pkt_valid <= 1'b0;
        else if (flush)               pkt_valid <= 1'b0;
        else if (done)                pkt_valid <= 1'b1;
        else if (pkt_valid && ready)  pkt_valid <= 1'b0;
    end

endmodule

// File: rtl/atapi_sense_regs.sv
// Module: sense byte bank loaded from a completion code.
// Assumes SENSE_BYTES is at least 9 so bytes 0, 2 and 8 exist.
module atapi_sense_regs #(
    parameter int SENSE_BYTES = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     load,
    input  logic [15:0]              code,
    output logic [SENSE_BYTES*8-1:0] sense
);
    import atapi_pkg::*;

    // Sense bank: cleared on reset or device reset, filled on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sense <= '0;
        end else if (load) begin
            sense[0*8 +: 8] <= SENSE_TAG;
            sense[2*8 +: 8] <= code[7:0];
            sense[8*8 +: 8] <= code[15:8];
        end
    end

endmodule

// File: rtl/atapi_irq_ctrl.sv
// Module: tracks one pending interrupt and emits raise/clear pulses.
// Assumes a command write clears the pending request before any new raise.
module atapi_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_req,
    input  logic raise_req,
    output logic irq_raise,
    output logic irq_clear
);
    logic pending;

    // Pending flag and pulse generation, raise taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            irq_raise <= 1'b0;
            irq_clear <= 1'b0;
        end else begin
            irq_raise <= 1'b0;
            irq_clear <= 1'b0;
            if (raise_req) begin
                if (!pending || clear_req) irq_raise <= 1'b1;
                pending <= 1'b1;
            end else if (clear_req) begin
                if (pending) irq_clear <= 1'b1;
                pending <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/atapi_cmd_intake.sv
// Module: task-file command state machine with packet intake.
// Assumes one host access class per strobe; a command write has priority
// over a completion code presented in the same cycle.
module atapi_cmd_intake #(
    parameter int PKT_BYTES   = 12,
    parameter int SENSE_BYTES = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_we,
    input  logic [7:0]               cmd_data,
    input  logic                     feat_we,
    input  logic [7:0]               feat_data,
    input  logic                     cnt_we,
    input  logic [7:0]               cnt_data,
    input  logic                     pio_we,
    input  logic [15:0]              pio_data,
    output logic                     pkt_valid,
    input  logic                     pkt_ready,
    output logic [PKT_BYTES*8-1:0]   pkt_data,
    input  logic                     res_valid,
    input  logic [15:0]              res_code,
    output logic [7:0]               status,
    output logic [7:0]               error,
    output logic [7:0]               count,
    output logic [7:0]               bcnt_lo,
    output logic [7:0]               bcnt_hi,
    output logic [7:0]               sector,
    output logic [SENSE_BYTES*8-1:0] sense,
    output logic [4:0]               xfer_class,
    output logic                     irq_raise,
    output logic                     irq_clear
);
    import atapi_pkg::*;

    tf_state_t  state, n_state;
    logic [7:0] feature, n_feature;
    logic [7:0] n_status, n_error, n_count, n_bclo, n_bchi, n_sector;
    logic [4:0] n_xclass;
    logic       wr_en, pkt_done, res_take, raise_req, dev_reset;

    // Intake gating: data words only count in the command-write phase.
    always_comb begin
        wr_en     = pio_we && (state == TF_CMDWR) && !cmd_we;
        res_take  = res_valid && !cmd_we && (state == TF_BUSY) && !pkt_valid;
        dev_reset = cmd_we && (cmd_data == OP_DEVRST);
        raise_req = (cmd_we && (cmd_data == OP_NOP || cmd_data == OP_SETFEAT))
                 || (res_take && res_code != 16'h0000);
    end

    atapi_pkt_collect #(.PKT_BYTES(PKT_BYTES)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_we),
        .wr_en     (wr_en),
        .wr_word   (pio_data),
        .ready     (pkt_ready),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .done      (pkt_done)
    );

    atapi_sense_regs #(.SENSE_BYTES(SENSE_BYTES)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dev_reset),
        .load  (res_take),
        .code  (res_code),
        .sense (sense)
    );

    atapi_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_req (cmd_we),
        .raise_req (raise_req),
        .irq_raise (irq_raise),
        .irq_clear (irq_clear)
    );

    // Next-state: register writes, packet end, completion, then command.
    always_comb begin
        n_state   = state;
        n_feature = feat_we ? feat_data : feature;
        n_status  = status;
        n_error   = error;
        n_count   = cnt_we ? cnt_data : count;
        n_bclo    = bcnt_lo;
        n_bchi    = bcnt_hi;
        n_sector  = sector;
        n_xclass  = xfer_class;

        if (pkt_done) begin
            n_state  = TF_BUSY;
            n_status = (status & ~SB_DRQ) | SB_BSY;
        end

        if (res_take) begin
            n_state = TF_IDLE;
            n_error = {res_code[3:0], 4'h0};
            if (res_code != 16'h0000) n_status = STAT_FAIL;
            else                      n_status = status & ~(SB_BSY | SB_CHK);
        end

        if (cmd_we) begin
            case (cmd_data)
                OP_NOP: begin
                    n_state  = TF_IDLE;
                    n_status = STAT_FAIL;
                    n_error  = ERR_ABORTED;
                end
                OP_DEVRST: begin
                    n_state   = TF_IDLE;
                    n_status  = RST_STATUS;
                    n_error   = RST_ERROR;
                    n_count   = RST_COUNT;
                    n_bclo    = RST_BCLO;
                    n_bchi    = RST_BCHI;
                    n_sector  = RST_SECTOR;
                    n_feature = 8'h00;
                end
                OP_PACKET: begin
                    n_state  = TF_CMDWR;
                    n_status = SB_DRDY | SB_DRQ;
                    n_error  = {6'b0, feature[1:0]};
                    n_count  = IRSN_CMD;
                end
                OP_SETFEAT: begin
                    if (feature == FEAT_XMODE) n_xclass = count[7:3];
                end
                default: ;
            endcase
            if (cmd_data != OP_NOP)
                n_status = (n_status | SB_DRDY | SB_SERV) & ~SB_CHK;
        end
    end

    // Task-file registers: reset image or next-state values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TF_IDLE;
            feature    <= 8'h00;
            status     <= RST_STATUS;
            error      <= RST_ERROR;
            count      <= RST_COUNT;
            bcnt_lo    <= RST_BCLO;
            bcnt_hi    <= RST_BCHI;
            sector     <= RST_SECTOR;
            xfer_class <= 5'd0;
        end else begin
            state      <= n_state;
            feature    <= n_feature;
            status     <= n_status;
            error      <= n_error;
            count      <= n_count;
            bcnt_lo    <= n_bclo;
            bcnt_hi    <= n_bchi;
            sector     <= n_sector;
            xfer_class <= n_xclass;
        end
    end

endmodule

// File: rtl/atapi_cmd_intake_chk.sv
// Module: protocol checker for atapi_cmd_intake, attached by bind.
// Assumes the port-level view only; no internal state is observed.
module atapi_cmd_intake_chk #(
    parameter int PKT_BYTES = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_we,
    input logic [7:0]             cmd_data,
    input logic                   res_valid,
    input logic [15:0]            res_code,
    input logic                   pkt_valid,
    input logic                   pkt_ready,
    input logic [PKT_BYTES*8-1:0] pkt_data,
    input logic [7:0]             status,
    input logic [7:0]             error,
    input logic [7:0]             count,
    input logic                   irq_raise,
    input logic                   irq_clear
);
    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && !cmd_we) |=> (pkt_valid && $stable(pkt_data))); // R5
    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> status[7]); // R3
    AST_NO_BSY_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[7] && status[3])); // R3
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_raise && irq_clear)); // R12
    AST_NOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data == 8'h00) |=> (status == 8'h51 && error == 8'h04 && irq_raise)); // R9
    AST_PKT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data == 8'hA0) |=> (status == 8'h58 && count == 8'h01)); // R2
    AST_RES_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cmd_we && status[7] && !pkt_valid)
        |=> (error == {$past(res_code[3:0]), 4'h0})); // R6
endmodule

bind atapi_cmd_intake atapi_cmd_intake_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_data  (cmd_data),
    .res_valid (res_valid),
    .res_code  (res_code),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_data  (pkt_data),
    .status    (status),
    .error     (error),
    .count     (count),
    .irq_raise (irq_raise),
    .irq_clear (irq_clear)
);

// File: tb/atapi_cmd_intake_tb.sv
// Bench: directed scenarios for atapi_cmd_intake, one task each.
module atapi_cmd_intake_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        feat_we = 1'b0;
    logic [7:0]  feat_data = '0;
    logic        cnt_we = 1'b0;
    logic [7:0]  cnt_data = '0;
    logic        pio_we = 1'b0;
    logic [15:0] pio_data = '0;
    logic        pkt_ready = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_code = '0;
    logic        pkt_valid;
    logic [95:0] pkt_data;
    logic [7:0]  status, error, count, bcnt_lo, bcnt_hi, sector;
    logic [79:0] sense;
    logic [4:0]  xfer_class;
    logic        irq_raise, irq_clear;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    localparam logic [95:0] PKT_A = 96'h0b0a09080706050403020100;

    always #10 clk = ~clk;

    atapi_cmd_intake u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .feat_we(feat_we), .feat_data(feat_data), .cnt_we(cnt_we), .cnt_data(cnt_data),
        .pio_we(pio_we), .pio_data(pio_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_data(pkt_data), .res_valid(res_valid), .res_code(res_code), .status(status),
        .error(error), .count(count), .bcnt_lo(bcnt_lo), .bcnt_hi(bcnt_hi), .sector(sector),
        .sense(sense), .xfer_class(xfer_class), .irq_raise(irq_raise), .irq_clear(irq_clear)
    );

    task automatic chk(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] sb(input int i);
        return sense[8*i +: 8];
    endfunction

    task automatic wr_cmd(input logic [7:0] v);
        @(negedge clk); cmd_we = 1'b1; cmd_data = v;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wr_feat(input logic [7:0] v);
        @(negedge clk); feat_we = 1'b1; feat_data = v;
        @(negedge clk); feat_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_data = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wr_pio(input logic [15:0] v);
        @(negedge clk); pio_we = 1'b1; pio_data = v;
        @(negedge clk); pio_we = 1'b0;
    endtask

    task automatic send_res(input logic [15:0] c);
        @(negedge clk); res_valid = 1'b1; res_code = c;
        @(negedge clk); res_valid = 1'b0;
    endtask

    task automatic accept_pkt();
        @(negedge clk); pkt_ready = 1'b1;
        @(negedge clk); pkt_ready = 1'b0;
    endtask

    task automatic load_packet(input logic [95:0] p);
        wr_cmd(8'hA0);
        for (int k = 0; k < 6; k++) wr_pio(p[16*k +: 16]);
    endtask

    task automatic t_reset_image();
        chk("R1", "status", status, 8'h50);
        chk("R1", "error", error, 8'h01);
        chk("R1", "count", count, 8'h01);
        chk("R1", "bcnt_lo", bcnt_lo, 8'h81);
        chk("R1", "bcnt_hi", bcnt_hi, 8'hEB);
        chk("R1", "sector", sector, 8'h14);
        chk("R1", "sense", sense, 80'h0);
        chk("R1", "pkt_valid", pkt_valid, 1'b0);
    endtask

    task automatic t_ignored_inputs();
        send_res(16'h0005);
        chk("R8", "status after stray code", status, 8'h50);
        chk("R8", "sense after stray code", sense, 80'h0);
        chk("R8", "no raise", irq_raise, 1'b0);
        wr_pio(16'hDEAD);
        wr_pio(16'hBEEF);
        chk("R4", "status after idle pio", status, 8'h50);
    endtask

    task automatic t_packet_intake();
        wr_feat(8'h03);
        wr_cmd(8'hA0);
        chk("R2", "status", status, 8'h58);
        chk("R2", "count", count, 8'h01);
        chk("R2", "error", error, 8'h03);
        chk("R12", "no clear when idle", irq_clear, 1'b0);
        for (int k = 0; k < 5; k++) wr_pio(PKT_A[16*k +: 16]);
        chk("R3", "valid before last word", pkt_valid, 1'b0);
        chk("R3", "status before last word", status, 8'h58);
        wr_pio(PKT_A[80 +: 16]);
        chk("R3", "valid after last word", pkt_valid, 1'b1);
        chk("R3", "status after last word", status, 8'hD0);
        chk("R4", "data ignored earlier", pkt_data, PKT_A);
        wr_pio(16'hFFFF);
        chk("R4", "busy pio ignored", pkt_data, PKT_A);
        repeat (3) @(negedge clk);
        chk("R5", "valid held", pkt_valid, 1'b1);
        chk("R5", "data held", pkt_data, PKT_A);
        send_res(16'h0009);
        chk("R8", "code ignored before accept", status, 8'hD0);
        accept_pkt();
        chk("R5", "valid dropped", pkt_valid, 1'b0);
    endtask

    task automatic t_result_zero();
        send_res(16'h0000);
        chk("R7", "zero status", status, 8'h50);
        chk("R7", "zero no raise", irq_raise, 1'b0);
        chk("R6", "zero error", error, 8'h00);
        chk("R6", "sense0", sb(0), 8'hF0);
        chk("R6", "sense2", sb(2), 8'h00);
        chk("R6", "sense8", sb(8), 8'h00);
    endtask

    task automatic t_result_nonzero();
        logic [95:0] p;
        p = 96'h1122334455667788_99aabbcc;
        wr_feat(8'h02);
        load_packet(p);
        chk("R2", "error from feature", error, 8'h02);
        chk("R3", "second packet", pkt_data, p);
        accept_pkt();
        send_res(16'h2306);
        chk("R7", "fail status", status, 8'h51);
        chk("R7", "raise pulse", irq_raise, 1'b1);
        chk("R6", "error nibble", error, 8'h60);
        chk("R6", "sense2", sb(2), 8'h06);
        chk("R6", "sense8", sb(8), 8'h23);
    endtask

    task automatic t_clear_pulse();
        wr_cmd(8'hA0);
        chk("R12", "clear pulse", irq_clear, 1'b1);
        chk("R12", "no raise", irq_raise, 1'b0);
        chk("R11", "status", status, 8'h58);
        for (int k = 0; k < 6; k++) wr_pio(PKT_A[16*k +: 16]);
        accept_pkt();
    endtask

    task automatic t_collision();
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = 8'h00; res_valid = 1'b1; res_code = 16'h0107;
        @(negedge clk);
        cmd_we = 1'b0; res_valid = 1'b0;
        chk("R13", "status", status, 8'h51);
        chk("R13", "error", error, 8'h04);
        chk("R13", "sense2 kept", sb(2), 8'h06);
        chk("R13", "sense8 kept", sb(8), 8'h23);
        chk("R9", "raise pulse", irq_raise, 1'b1);
        chk("R12", "no clear with raise", irq_clear, 1'b0);
        wr_pio(16'h1234);
        chk("R9", "idle after abort", status, 8'h51);
    endtask

    task automatic t_set_feature();
        wr_feat(8'h03);
        wr_cnt(8'h0B);
        wr_cmd(8'hEF);
        chk("R10", "class", xfer_class, 5'h01);
        chk("R10", "raise", irq_raise, 1'b1);
        chk("R11", "status", status, 8'h50);
        wr_feat(8'h02);
        wr_cnt(8'h20);
        wr_cmd(8'hEF);
        chk("R10", "class unchanged", xfer_class, 5'h01);
        wr_cmd(8'h00);
        wr_cmd(8'h55);
        chk("R11", "unknown opcode", status, 8'h50);
    endtask

    task automatic t_device_reset();
        wr_cnt(8'h77);
        wr_cmd(8'h08);
        t_reset_image();
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_image();
        t_ignored_inputs();
        t_packet_intake();
        t_result_zero();
        t_result_nonzero();
        t_clear_pulse();
        t_collision();
        t_set_feature();
        t_device_reset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule